// File: doc/BRIEF.md
# I2C Arbitration Loss Detector

This block sits beside an I2C transmitter and tells it when it has lost arbitration to another master on the bus. It sees the synchronized SCL and SDA line levels, the bit the transmitter is currently driving, and the position of that bit within the nine-clock frame. On each rising SCL edge where the block is transmitting, it compares the driven bit with the level read back from SDA. A difference means another master is holding the line low.

The flag can follow one of two update policies. In per-bit mode it sets straight after the edge that shows the mismatch. In per-byte mode mismatches are collected across the byte, and the flag is raised only when SCL falls at the end of the ninth clock. The flag is sticky until software clears it.

An output-enable gate lets the SDA driver let go of the line. The gate drops in the same cycle the flag rises when automatic release is enabled. It also drops at any time while the force-release input is high.

Top module: `i2c_arb_monitor`

## Requirements
- R1: A comparison happens only in the clock cycle after SCL goes from 0 to 1. A difference between `tx_bit` and `sda_in` while SCL is steady never sets `arb_lost`.
- R2: With `byte_mode` = 0 (per-bit), a rising SCL edge where `tx_active` = 1 and `tx_bit` differs from `sda_in` makes `arb_lost` read 1 in the following cycle. Matching bits leave it at 0.
- R3: With `byte_mode` = 1 (per-byte), a mismatch at any bit of the byte does not change `arb_lost` before the end of the byte. The flag becomes 1 in the cycle after SCL falls while `bit_idx` = 8 (the ninth clock; bits are indexed 0 to 8).
- R4: The per-byte mismatch memory restarts at the rising SCL edge with `bit_idx` = 0. After the flag is cleared, a following byte with no mismatch leaves `arb_lost` at 0 at its ninth falling edge.
- R5: Once `arb_lost` is set it holds until `clear_flag` = 1 is seen on a clock edge. If a new set condition arrives in the same cycle as the clear, the flag stays 1.
- R6: While `tx_active` = 0 (for example, while the peer drives ACK), no mismatch is recorded in either mode.
- R7: `sda_oe` (1 = driver may drive SDA) is 0 in every cycle where `release_on_loss` = 1 and `arb_lost` = 1. This includes the first cycle the flag reads 1. With `release_on_loss` = 0 the flag does not affect `sda_oe`.
- R8: While `force_release` = 1, `sda_oe` is 0 whatever the flag is.
- R9: A synchronous active-low `rst_n` clears `arb_lost` and the per-byte mismatch memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| tx_bit | input | 1 | Bit currently driven by this master |
| tx_active | input | 1 | 1 while this master drives the current bit |
| bit_idx | input | IDX_W | Bit position in the frame, 0..7 data, 8 = ninth clock |
| byte_mode | input | 1 | 0 = per-bit update, 1 = per-byte update |
| release_on_loss | input | 1 | 1 = drop `sda_oe` while the flag is set |
| force_release | input | 1 | 1 = drop `sda_oe` unconditionally |
| clear_flag | input | 1 | Clears `arb_lost` |
| arb_lost | output | 1 | Arbitration-lost flag |
| sda_oe | output | 1 | SDA driver enable gate |

## Verification
The bench targets the exact cycle of each flag change. In per-byte mode it samples the flag after the ninth rising edge and again after the ninth falling edge. A design that updated on the wrong edge would show the flag one half-clock early. It also changes SDA while SCL is held high, which exposes a level-sensitive comparator as a false loss. It drives a mismatch during the peer-driven ACK, which a design ignoring `tx_active` would treat as a loss. A clean byte after a clear exposes a mismatch memory that never restarts, because the flag would come back. A clear coinciding with a fresh mismatch shows whether clear wrongly takes priority. Reset in the middle of a byte shows whether stale mismatch state survives.

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int IDX_W   = 4,
  parameter int ACK_IDX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             tx_bit,
  input  logic             tx_active,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             byte_mode,
  input  logic             release_on_loss,
  input  logic             force_release,
  input  logic             clear_flag,
  output logic             arb_lost,
  output logic             sda_oe
);

  logic scl_q;
  logic miss_acc;

  wire scl_rise  = scl_in & ~scl_q;
  wire scl_fall  = ~scl_in & scl_q;
  wire miss      = scl_rise & tx_active & (tx_bit ^ sda_in);
  wire first_bit = (bit_idx == '0);
  wire byte_end  = scl_fall & (bit_idx == IDX_W'(ACK_IDX));
  wire set_now   = byte_mode ? (byte_end & miss_acc) : miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q    <= scl_in;
      miss_acc <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      scl_q <= scl_in;
      if (scl_rise)
        miss_acc <= first_bit ? miss : (miss_acc | miss);
      if (set_now)
        arb_lost <= 1'b1;
      else if (clear_flag)
        arb_lost <= 1'b0;
    end
  end

  assign sda_oe = ~force_release & ~(release_on_loss & arb_lost);

  assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_mode && !arb_lost && !$rose(scl_in)) |=> !arb_lost);

  assert_perbit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_mode && scl_rise && tx_active && (tx_bit != sda_in)) |=> arb_lost);

  assert_byte_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && !byte_end && !arb_lost) |=> !arb_lost);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_flag && !set_now) |=> !arb_lost);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clear_flag) |=> arb_lost);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_mode && !tx_active && !arb_lost) |=> !arb_lost);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_on_loss && arb_lost) |-> !sda_oe);

  assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_release |-> !sda_oe);

endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b0, sda_in = 1'b1, tx_bit = 1'b1, tx_active = 1'b0;
  logic [3:0] bit_idx = '0;
  logic byte_mode = 1'b0, release_on_loss = 1'b0, force_release = 1'b0, clear_flag = 1'b0;
  logic arb_lost, sda_oe;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_arb_monitor uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .tx_bit(tx_bit),
    .tx_active(tx_active), .bit_idx(bit_idx), .byte_mode(byte_mode),
    .release_on_loss(release_on_loss), .force_release(force_release),
    .clear_flag(clear_flag), .arb_lost(arb_lost), .sda_oe(sda_oe));

  task automatic chk(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_setup(logic tb, logic sd, int idx, logic act);
    tx_bit = tb; sda_in = sd; bit_idx = 4'(idx); tx_active = act; scl_in = 1'b0;
    cyc(2);
  endtask

  task automatic rise(); scl_in = 1'b1; cyc(1); endtask
  task automatic fall(); cyc(1); scl_in = 1'b0; cyc(2); endtask

  task automatic send_byte(logic [7:0] d, logic [7:0] line);
    for (int i = 0; i < 8; i++) begin
      bit_setup(d[7-i], line[7-i], i, 1'b1);
      rise(); fall();
    end
  endtask

  task automatic do_clear();
    clear_flag = 1'b1; cyc(1); clear_flag = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    chk("R9 reset flag", arb_lost, 1'b0);
    chk("R9 reset oe", sda_oe, 1'b1);
  endtask

  task automatic t_perbit();
    byte_mode = 1'b0;
    send_byte(8'hA5, 8'hA5);
    bit_setup(1'b0, 1'b0, 8, 1'b0); rise(); fall();
    chk("R2 matching byte", arb_lost, 1'b0);
    bit_setup(1'b1, 1'b1, 0, 1'b1); rise(); fall();
    bit_setup(1'b1, 1'b0, 1, 1'b1); rise();
    chk("R2 set after edge", arb_lost, 1'b1);
    chk("R7 no release when disabled", sda_oe, 1'b1);
    fall();
    bit_setup(1'b0, 1'b0, 2, 1'b1); rise(); fall();
    chk("R5 sticky", arb_lost, 1'b1);
    do_clear();
    chk("R5 clear", arb_lost, 1'b0);
  endtask

  task automatic t_release();
    byte_mode = 1'b0; release_on_loss = 1'b1;
    bit_setup(1'b1, 1'b0, 3, 1'b1);
    chk("R7 oe before loss", sda_oe, 1'b1);
    rise();
    chk("R7 flag up", arb_lost, 1'b1);
    chk("R7 oe same cycle", sda_oe, 1'b0);
    fall(); do_clear();
    chk("R7 oe back", sda_oe, 1'b1);
    release_on_loss = 1'b0;
  endtask

  task automatic t_level();
    byte_mode = 1'b0;
    bit_setup(1'b1, 1'b1, 4, 1'b1); rise();
    sda_in = 1'b0; cyc(3);
    chk("R1 no compare while high", arb_lost, 1'b0);
    fall();
    chk("R1 after fall", arb_lost, 1'b0);
  endtask

  task automatic t_idle();
    byte_mode = 1'b0;
    bit_setup(1'b1, 1'b0, 8, 1'b0); rise(); fall();
    chk("R6 per-bit ack ignored", arb_lost, 1'b0);
    byte_mode = 1'b1;
    send_byte(8'hFF, 8'hFF);
    bit_setup(1'b1, 1'b0, 8, 1'b0); rise(); fall();
    chk("R6 per-byte ack ignored", arb_lost, 1'b0);
  endtask

  task automatic t_bytemode();
    byte_mode = 1'b1;
    send_byte(8'hF0, 8'hD0);
    chk("R3 no flag mid byte", arb_lost, 1'b0);
    bit_setup(1'b0, 1'b0, 8, 1'b0); rise();
    chk("R3 no flag at ninth rise", arb_lost, 1'b0);
    cyc(1); scl_in = 1'b0; cyc(1);
    chk("R3 flag at ninth fall", arb_lost, 1'b1);
    cyc(1);
    do_clear();
    chk("R3 cleared", arb_lost, 1'b0);
    send_byte(8'h3C, 8'h3C);
    bit_setup(1'b0, 1'b0, 8, 1'b0); rise(); fall();
    chk("R4 clean byte after clear", arb_lost, 1'b0);
  endtask

  task automatic t_clear_race();
    byte_mode = 1'b0;
    bit_setup(1'b1, 1'b0, 5, 1'b1);
    scl_in = 1'b1; clear_flag = 1'b1; cyc(1); clear_flag = 1'b0;
    chk("R5 set beats clear", arb_lost, 1'b1);
    fall(); do_clear();
  endtask

  task automatic t_force();
    force_release = 1'b1; cyc(1);
    chk("R8 force with no loss", sda_oe, 1'b0);
    chk("R8 flag untouched", arb_lost, 1'b0);
    force_release = 1'b0; cyc(1);
    chk("R8 release off", sda_oe, 1'b1);
  endtask

  task automatic t_reset_mid();
    byte_mode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bit_setup(1'b1, (i == 2) ? 1'b0 : 1'b1, i, 1'b1); rise(); fall();
    end
    rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
    for (int i = 4; i < 8; i++) begin
      bit_setup(1'b1, 1'b1, i, 1'b1); rise(); fall();
    end
    bit_setup(1'b0, 1'b0, 8, 1'b0); rise(); fall();
    chk("R9 memory cleared by reset", arb_lost, 1'b0);
    byte_mode = 1'b0;
    bit_setup(1'b1, 1'b0, 0, 1'b1); rise(); fall();
    rst_n = 1'b0; cyc(1); rst_n = 1'b1;
    chk("R9 flag cleared by reset", arb_lost, 1'b0);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_perbit();
    t_release();
    t_level();
    t_idle();
    t_bytemode();
    t_clear_race();
    t_force();
    t_reset_mid();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule